// File: doc/BRIEF.md
# Harvard Accumulator Sequencer

This block is a small accumulator processor. The program and the data are kept in two separate memories. A program counter selects a 2-bit command from the program store, and the same counter value addresses a word of the data RAM. Each enabled clock executes one command. A command either copies the addressed data word into the accumulator, adds that word to the accumulator, writes the accumulator back into the addressed word, or does nothing.

The low bit of the command steers the multiplexer that selects the accumulator's next value. The high bit, decoded together with the low bit, gates the write enable of the data RAM. Both memories can be filled through preload ports before or between runs. A combinational peek port reads any data word, and the accumulator and program counter are output directly, so the effects of a program can be watched from outside.

Top module: `acc_harvard_core`

## Requirements
- R1: While reset is high, at the next clock edge the accumulator and the program counter both become zero. Memory contents are left as they are.
- R2: When step is high, the command at program address pc is executed on data address pc, and pc then advances by one.
- R3: When step is low, the accumulator, the program counter and the data RAM all keep their values.
- R4: Command code 2'b10 (load) sets the accumulator to data word [pc].
- R5: Command code 2'b00 (add) sets the accumulator to (accumulator + data word [pc]) modulo 2^DATA_W. The carry out is discarded.
- R6: Command code 2'b01 (store) writes the accumulator into data word [pc] and leaves the accumulator unchanged. The new word is visible on the peek port after that edge.
- R7: Command code 2'b11 is a no-operation. The accumulator and the data RAM are unchanged, and pc still advances.
- R8: The preload ports write a command or a data word at the next edge when their enable is high. If a data preload and a store target the same word in the same cycle, the preloaded value is the one kept.
- R9: The program counter wraps from 2^ADDR_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Execute one command on this edge |
| prog_wr_en | input | 1 | Program preload enable |
| prog_wr_addr | input | ADDR_W | Program preload address |
| prog_wr_cmd | input | 2 | Program preload command |
| dmem_wr_en | input | 1 | Data preload enable |
| dmem_wr_addr | input | ADDR_W | Data preload address |
| dmem_wr_data | input | DATA_W | Data preload word |
| peek_addr | input | ADDR_W | Data RAM observation address |
| peek_data | output | DATA_W | Data word at peek_addr (combinational) |
| acc_q | output | DATA_W | Accumulator |
| pc_q | output | ADDR_W | Program counter |

## Verification
The bench sweeps the whole program store under several command patterns, including an all-no-operation program. The data words are chosen so that additions overflow, and a design that kept the carry or saturated would show a wrong accumulator. Every run takes more steps than the depth, so a counter that stopped or reset at the top address would be caught. Idle cycles are inserted between steps, and a block that advanced without step would drift. At the end of each run every data word is peeked, which exposes a store that clobbered the accumulator, a store to the wrong address, or a no-operation that wrote memory. A store collides with a preload of the same word once, which shows whether the preload priority is wrong.

// File: rtl/acc_pkg.sv
package acc_pkg;
   typedef enum logic [1:0] {
      CMD_ADD   = 2'b00,
      CMD_STORE = 2'b01,
      CMD_LOAD  = 2'b10,
      CMD_NOP   = 2'b11
   } cmd_e;
endpackage

// File: rtl/acc_prog_store.sv
module acc_prog_store #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [1:0]        wr_cmd,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [1:0]        rd_cmd
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_cmd;
   end

   assign rd_cmd = cells[rd_addr];
endmodule

// File: rtl/acc_data_ram.sv
module acc_data_ram #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              st_en,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [ADDR_W-1:0] pk_addr,
   output logic [DATA_W-1:0] pk_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_q [DEPTH];
   // write data is only released onto the cells while a store is enabled
   logic [DATA_W-1:0] st_bus;
   assign st_bus = st_en ? st_data : '0;

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic hit_ld, hit_st;
      assign hit_ld = ld_en && (ld_addr == ADDR_W'(w));
      assign hit_st = st_en && (st_addr == ADDR_W'(w));
      always_ff @(posedge clk) begin
         if (hit_ld)      word_q[w] <= ld_data;
         else if (hit_st) word_q[w] <= st_bus;
      end
   end

   assign rd_data = word_q[rd_addr];
   assign pk_data = word_q[pk_addr];
endmodule

// File: rtl/acc_alu_reg.sv
module acc_alu_reg
   import acc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic [1:0]        cmd,
   input  logic [DATA_W-1:0] mem_word,
   output logic [DATA_W-1:0] acc_q
);
   logic [DATA_W-1:0] sum;

   if (RIPPLE) begin : g_ripple
      logic [DATA_W:0] cy;
      assign cy[0] = 1'b0;
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign sum[b]  = acc_q[b] ^ mem_word[b] ^ cy[b];
         assign cy[b+1] = (acc_q[b] & mem_word[b]) | (cy[b] & (acc_q[b] ^ mem_word[b]));
      end
   end else begin : g_behav
      assign sum = acc_q + mem_word;
   end

   // low command bit: 0 takes a value sourced from memory, 1 keeps the register
   logic [DATA_W-1:0] mem_src, nxt;
   assign mem_src = cmd[1] ? mem_word : sum;
   assign nxt     = cmd[0] ? acc_q : mem_src;

   always_ff @(posedge clk) begin
      if (rst)       acc_q <= '0;
      else if (step) acc_q <= nxt;
   end
endmodule

// File: rtl/acc_harvard_core.sv
module acc_harvard_core
   import acc_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic              prog_wr_en,
   input  logic [ADDR_W-1:0] prog_wr_addr,
   input  logic [1:0]        prog_wr_cmd,
   input  logic              dmem_wr_en,
   input  logic [ADDR_W-1:0] dmem_wr_addr,
   input  logic [DATA_W-1:0] dmem_wr_data,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data,
   output logic [DATA_W-1:0] acc_q,
   output logic [ADDR_W-1:0] pc_q
);
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("acc_harvard_core: ADDR_W must be in 1..10");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("acc_harvard_core: DATA_W must be at least 2");
   end

   logic [1:0]        cmd;
   logic [DATA_W-1:0] rd_word;
   logic              store_en;

   acc_prog_store #(.ADDR_W(ADDR_W)) u_prog (
      .clk(clk), .wr_en(prog_wr_en), .wr_addr(prog_wr_addr), .wr_cmd(prog_wr_cmd),
      .rd_addr(pc_q), .rd_cmd(cmd)
   );

   // high command bit decodes the write strobe (only 01 writes)
   assign store_en = step && !cmd[1] && cmd[0];

   acc_data_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dram (
      .clk(clk),
      .ld_en(dmem_wr_en), .ld_addr(dmem_wr_addr), .ld_data(dmem_wr_data),
      .st_en(store_en), .st_addr(pc_q), .st_data(acc_q),
      .rd_addr(pc_q), .rd_data(rd_word),
      .pk_addr(peek_addr), .pk_data(peek_data)
   );

   acc_alu_reg #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_acc (
      .clk(clk), .rst(rst), .step(step), .cmd(cmd), .mem_word(rd_word), .acc_q(acc_q)
   );

   always_ff @(posedge clk) begin
      if (rst)       pc_q <= '0;
      else if (step) pc_q <= pc_q + 1'b1;
   end
endmodule

// File: rtl/acc_harvard_chk.sv
module acc_harvard_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              step,
   input logic [1:0]        cmd,
   input logic [DATA_W-1:0] rd_word,
   input logic [DATA_W-1:0] acc_q,
   input logic [ADDR_W-1:0] pc_q
);
   AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      step |=> pc_q == $past(pc_q) + 1'b1); // R2
   AST_PC_IDLE: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(pc_q)); // R3
   AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(acc_q)); // R3
   AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (rst)
      (step && cmd == 2'b10) |=> acc_q == $past(rd_word)); // R4
   AST_ADD_WRAPS: assert property (@(posedge clk) disable iff (rst)
      (step && cmd == 2'b00) |=> acc_q == DATA_W'($past(acc_q) + $past(rd_word))); // R5
   AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
      (step && cmd == 2'b01) |=> $stable(acc_q)); // R6
   AST_NOP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
      (step && cmd == 2'b11) |=> $stable(acc_q)); // R7
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (acc_q == '0 && pc_q == '0)); // R1
endmodule

bind acc_harvard_core acc_harvard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .step(step), .cmd(cmd), .rd_word(rd_word),
   .acc_q(acc_q), .pc_q(pc_q)
);

// File: tb/acc_harvard_core_tb.sv
module acc_harvard_core_tb;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   logic clk = 0;
   logic rst, step, prog_wr_en, dmem_wr_en;
   logic [AW-1:0] prog_wr_addr, dmem_wr_addr, peek_addr, pc_q;
   logic [1:0] prog_wr_cmd;
   logic [DW-1:0] dmem_wr_data, peek_data, acc_q;

   int n_cmp = 0, n_bad = 0;
   int m_prog [DEPTH];
   int m_mem [DEPTH];
   int m_acc, m_pc;

   always #2 clk = ~clk;

   acc_harvard_core #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst(rst), .step(step),
      .prog_wr_en(prog_wr_en), .prog_wr_addr(prog_wr_addr), .prog_wr_cmd(prog_wr_cmd),
      .dmem_wr_en(dmem_wr_en), .dmem_wr_addr(dmem_wr_addr), .dmem_wr_data(dmem_wr_data),
      .peek_addr(peek_addr), .peek_data(peek_data), .acc_q(acc_q), .pc_q(pc_q)
   );

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic preload(int p);
      for (int i = 0; i < DEPTH; i++) begin
         m_prog[i] = (p == 5) ? 3 : ((i * (p + 1) + p + (i >> 2)) % 4);
         m_mem[i]  = (i * 37 + p * 53 + 200) % 256;
         prog_wr_en = 1; prog_wr_addr = AW'(i); prog_wr_cmd = 2'(m_prog[i]);
         dmem_wr_en = 1; dmem_wr_addr = AW'(i); dmem_wr_data = DW'(m_mem[i]);
         tick();
      end
      prog_wr_en = 0; dmem_wr_en = 0;
   endtask

   task automatic do_step();
      int c;
      string tag;
      c = m_prog[m_pc];
      case (c)
         2: begin m_acc = m_mem[m_pc]; tag = "R4 load"; end
         0: begin m_acc = (m_acc + m_mem[m_pc]) % 256; tag = "R5 add"; end
         1: begin m_mem[m_pc] = m_acc; tag = "R6 store"; end
         default: tag = "R7 nop";
      endcase
      m_pc = (m_pc + 1) % DEPTH;
      step = 1; tick(); step = 0;
      chk(tag, int'(acc_q), m_acc);
      chk("R2 R9 pc", int'(pc_q), m_pc);
   endtask

   initial begin
      rst = 1; step = 0; prog_wr_en = 0; dmem_wr_en = 0;
      prog_wr_addr = '0; prog_wr_cmd = '0; dmem_wr_addr = '0; dmem_wr_data = '0; peek_addr = '0;
      tick(); tick();
      chk("R1 acc", int'(acc_q), 0);
      chk("R1 pc", int'(pc_q), 0);

      for (int p = 0; p < 6; p++) begin
         rst = 1;
         preload(p);
         rst = 0;
         m_acc = 0; m_pc = 0;
         for (int s = 0; s < DEPTH + 5; s++) begin
            do_step();
            if (s % 5 == 2) begin
               tick();
               chk("R3 acc idle", int'(acc_q), m_acc);
               chk("R3 pc idle", int'(pc_q), m_pc);
            end
         end
         for (int a = 0; a < DEPTH; a++) begin
            peek_addr = AW'(a); #1;
            chk("R6 R7 R3 R8 mem", int'(peek_data), m_mem[a]);
         end
      end

      // R8: a preload and a store hit the same word in one cycle
      rst = 1; preload(0); rst = 0; tick();
      prog_wr_en = 1; prog_wr_addr = 0; prog_wr_cmd = 2'b10; tick();
      prog_wr_addr = 1; prog_wr_cmd = 2'b01; tick(); prog_wr_en = 0;
      step = 1; tick(); step = 0;
      chk("R4 load before clash", int'(acc_q), m_mem[0]);
      step = 1; dmem_wr_en = 1; dmem_wr_addr = 1; dmem_wr_data = 8'h5A;
      tick(); step = 0; dmem_wr_en = 0;
      peek_addr = 1; #1;
      chk("R8 preload wins", int'(peek_data), 'h5A);
      chk("R6 acc kept", int'(acc_q), m_mem[0]);

      rst = 1; tick();
      chk("R1 acc again", int'(acc_q), 0);
      chk("R1 pc again", int'(pc_q), 0);
      peek_addr = 1; #1;
      chk("R1 mem kept", int'(peek_data), 'h5A);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule